// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block gathers completion events for up to 64 message buffers of a CAN-style controller and turns them into interrupts. Each buffer has one sticky flag bit and one mask bit. Both sets of bits are split across a low and a high 32-bit register. A flag sets when its buffer finishes a successful transmission or reception. Transmit and receive completions are treated the same way. Software clears a flag by writing 1 to it. Each buffer drives its own interrupt line, and a combined line is the OR of all enabled buffer interrupts.

When receive-FIFO mode is on, the low eight flag positions change meaning. Three of them carry FIFO status: overflow, warning and frames available. The five lowest are held at zero. A separate status register latches five more sources: bus off, error, transmit warning, receive warning and wake-up. Each has its own enable. The wake-up interrupt additionally requires a self-wake control bit. A configured-buffer-count input keeps flags at or above that count cleared.

All registers are reached through a small synchronous register bus. Reads are registered and have no side effects.

Top module: `mbi_irq_ctrl`

## Requirements
- R1: A pulse on `mb_done[i]` sets flag bit i on the next clock edge. The bit then stays set until software clears it. Transmit and receive completions are not distinguished.
- R2: Flags for buffers 0..31 read at address 0, bit i. Flags for buffers 32..63 read at address 1, bit i-32.
- R3: `mb_irq[i]` is high only while flag i and mask bit i are both set. Masks for buffers 0..31 are at address 2 and masks for buffers 32..63 are at address 3. An interrupt line rises or falls one cycle after its flag or mask changes.
- R4: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set event for that bit arrives in the same cycle as the clear, the flag stays set.
- R5: `mb_any_irq` equals the OR of all `mb_irq` lines.
- R6: Flag bits at positions greater than or equal to `cfg_num_mb` are held at zero. A bit already set is cleared on the edge after the count is lowered below its position.
- R7: Control bit 0 at address 6 enables FIFO mode. In that mode, `mb_done[7:0]` is ignored. Flag bit 7 sets from `fifo_ovf_evt`, bit 6 from `fifo_warn_evt` and bit 5 from `fifo_avail_evt`. Bits 4..0 read as zero and never raise an interrupt.
- R8: Mask, status-enable and control registers read back exactly the value last written.
- R9: The status flags at address 4 latch `stat_evt` with bit order bus off (0), error (1), transmit warning (2), receive warning (3), wake-up (4). They are cleared by writing 1. `stat_irq[j]` is high one cycle after both the flag and the enable at address 5, bit j, are set.
- R10: `stat_irq[4]` is raised only when the wake-up flag, enable bit 4 and self-wake (control bit 1 at address 6) are all set. It stays low in every other combination.
- R11: A synchronous active-high reset clears all flags, masks, enables, control bits and interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| cfg_num_mb | input | 7 | Number of configured buffers (0..64) |
| mb_done | input | 64 | Per-buffer completion pulses |
| fifo_ovf_evt | input | 1 | FIFO overflow event |
| fifo_warn_evt | input | 1 | FIFO warning event |
| fifo_avail_evt | input | 1 | FIFO frames-available event |
| stat_evt | input | 5 | Status source events |
| mb_irq | output | 64 | Per-buffer interrupt lines |
| mb_any_irq | output | 1 | OR of all buffer interrupts |
| stat_irq | output | 5 | Status interrupt lines |

## Verification
A completion or status event lands in the flag on the edge where it is sampled. A read issued in the following cycle sees it one edge later, on the cycle `bus_rvalid` is high. Interrupt lines trail any change to a flag, mask, enable or control bit by exactly one further edge. The bench therefore waits one extra falling edge after each write or event before it compares an interrupt output. The scoreboard queues the expected value for each read and compares it only in the cycle that `bus_rvalid` marks.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned N_STAT = 5;

  localparam logic [REG_AW-1:0] A_FLAG_LO = 3'd0;
  localparam logic [REG_AW-1:0] A_FLAG_HI = 3'd1;
  localparam logic [REG_AW-1:0] A_MASK_LO = 3'd2;
  localparam logic [REG_AW-1:0] A_MASK_HI = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT    = 3'd4;
  localparam logic [REG_AW-1:0] A_STAT_EN = 3'd5;
  localparam logic [REG_AW-1:0] A_CTRL    = 3'd6;

  localparam int unsigned ST_WAKE   = 4;
  localparam int unsigned FIFO_AVAIL = 5;
  localparam int unsigned FIFO_WARN  = 6;
  localparam int unsigned FIFO_OVF   = 7;
  localparam int unsigned FIFO_DEAD  = 5;  // bits below this unused in FIFO mode

  localparam int unsigned CTRL_FIFO_EN = 0;
  localparam int unsigned CTRL_SELF_WK = 1;
endpackage

// File: rtl/mbi_flag_word.sv
module mbi_flag_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] allow_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] irq_o,
  output logic         any_o
);
  logic [W-1:0] clr_v;

  always_comb clr_v = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= '0;
      mask_o <= '0;
      irq_o  <= '0;
      any_o  <= 1'b0;
    end else begin
      // set beats clear; disallowed positions forced low
      flag_o <= ((flag_o & ~clr_v) | set_i) & allow_i;
      if (mask_we_i) mask_o <= wdata_i;
      irq_o  <= flag_o & mask_o;
      any_o  <= |(flag_o & mask_o);
    end
  end
endmodule

// File: rtl/mbi_status.sv
module mbi_status #(
  parameter int unsigned N        = 5,
  parameter int unsigned WAKE_IDX = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [N-1:0] wdata_i,
  input  logic         self_wake_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] irq_o
);
  logic [N-1:0] gate;

  generate
    for (genvar j = 0; j < N; j++) begin : g_gate
      if (j == WAKE_IDX) begin : g_wake
        assign gate[j] = flag_o[j] & en_o[j] & self_wake_i;
      end else begin : g_plain
        assign gate[j] = flag_o[j] & en_o[j];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= '0;
      en_o   <= '0;
      irq_o  <= '0;
    end else begin
      flag_o <= (flag_o & ~(clr_we_i ? wdata_i : '0)) | evt_i;
      if (en_we_i) en_o <= wdata_i;
      irq_o <= gate;
    end
  end
endmodule

// File: rtl/mbi_irq_ctrl.sv
module mbi_irq_ctrl
  import mbi_pkg::*;
#(
  parameter int unsigned NUM_MB = 64,
  parameter int unsigned CW     = $clog2(NUM_MB + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wen,
  input  logic                bus_ren,
  input  logic [REG_AW-1:0]   bus_addr,
  input  logic [REG_DW-1:0]   bus_wdata,
  output logic [REG_DW-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [CW-1:0]       cfg_num_mb,
  input  logic [NUM_MB-1:0]   mb_done,
  input  logic                fifo_ovf_evt,
  input  logic                fifo_warn_evt,
  input  logic                fifo_avail_evt,
  input  logic [N_STAT-1:0]   stat_evt,
  output logic [NUM_MB-1:0]   mb_irq,
  output logic                mb_any_irq,
  output logic [N_STAT-1:0]   stat_irq
);
  localparam int unsigned NW = NUM_MB / REG_DW;

  logic                fifo_en, self_wake;
  logic [NUM_MB-1:0]   src_vec, allow_vec, flag_q, mask_q;
  logic [NW-1:0]       any_w;
  logic [N_STAT-1:0]   stat_flag, stat_en;
  logic [1:0][REG_DW-1:0] flag_pad, mask_pad;
  logic [REG_DW-1:0]   rd_mux;

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en   <= 1'b0;
      self_wake <= 1'b0;
    end else if (bus_wen && bus_addr == A_CTRL) begin
      fifo_en   <= bus_wdata[CTRL_FIFO_EN];
      self_wake <= bus_wdata[CTRL_SELF_WK];
    end
  end

  // set sources and allowed positions
  always_comb begin
    src_vec = mb_done;
    for (int i = 0; i < NUM_MB; i++) begin
      allow_vec[i] = (cfg_num_mb > CW'(i)) && !(fifo_en && i < FIFO_DEAD);
    end
    if (fifo_en) begin
      src_vec[FIFO_DEAD-1:0] = '0;
      src_vec[FIFO_AVAIL]    = fifo_avail_evt;
      src_vec[FIFO_WARN]     = fifo_warn_evt;
      src_vec[FIFO_OVF]      = fifo_ovf_evt;
    end
  end

  generate
    for (genvar w = 0; w < NW; w++) begin : g_word
      mbi_flag_word #(.W(REG_DW)) u_word (
        .clk      (clk),
        .rst      (rst),
        .set_i    (src_vec[w*REG_DW +: REG_DW]),
        .allow_i  (allow_vec[w*REG_DW +: REG_DW]),
        .clr_we_i (bus_wen && bus_addr == REG_AW'(A_FLAG_LO + w)),
        .mask_we_i(bus_wen && bus_addr == REG_AW'(A_MASK_LO + w)),
        .wdata_i  (bus_wdata),
        .flag_o   (flag_q[w*REG_DW +: REG_DW]),
        .mask_o   (mask_q[w*REG_DW +: REG_DW]),
        .irq_o    (mb_irq[w*REG_DW +: REG_DW]),
        .any_o    (any_w[w])
      );
    end
    for (genvar p = 0; p < 2; p++) begin : g_pad
      if (p < NW) begin : g_live
        assign flag_pad[p] = flag_q[p*REG_DW +: REG_DW];
        assign mask_pad[p] = mask_q[p*REG_DW +: REG_DW];
      end else begin : g_none
        assign flag_pad[p] = '0;
        assign mask_pad[p] = '0;
      end
    end
  endgenerate

  assign mb_any_irq = |any_w;

  mbi_status #(.N(N_STAT), .WAKE_IDX(ST_WAKE)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (stat_evt),
    .clr_we_i   (bus_wen && bus_addr == A_STAT),
    .en_we_i    (bus_wen && bus_addr == A_STAT_EN),
    .wdata_i    (bus_wdata[N_STAT-1:0]),
    .self_wake_i(self_wake),
    .flag_o     (stat_flag),
    .en_o       (stat_en),
    .irq_o      (stat_irq)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_FLAG_LO: rd_mux = flag_pad[0];
      A_FLAG_HI: rd_mux = flag_pad[1];
      A_MASK_LO: rd_mux = mask_pad[0];
      A_MASK_HI: rd_mux = mask_pad[1];
      A_STAT:    rd_mux[N_STAT-1:0] = stat_flag;
      A_STAT_EN: rd_mux[N_STAT-1:0] = stat_en;
      A_CTRL:    rd_mux[1:0] = {self_wake, fifo_en};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_ren;
      if (bus_ren) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mbi_irq_ctrl_chk.sv
module mbi_irq_ctrl_chk #(
  parameter int unsigned NUM_MB = 64,
  parameter int unsigned CW     = 7,
  parameter int unsigned NS     = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_MB-1:0] mb_irq,
  input logic              mb_any_irq,
  input logic [NS-1:0]     stat_irq,
  input logic [CW-1:0]     cfg_num_mb,
  input logic [NUM_MB-1:0] flag_q,
  input logic [NUM_MB-1:0] src_vec,
  input logic              fifo_en,
  input logic              self_wake,
  input logic [NS-1:0]     stat_en
);
  p_any_or_r5: assert property (@(posedge clk) disable iff (rst)
    mb_any_irq == (|mb_irq));

  p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((flag_q & ~$past(flag_q) & ~$past(src_vec)) == '0));

  p_count_limit_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((flag_q & ({NUM_MB{1'b1}} << $past(cfg_num_mb))) == '0));

  p_fifo_low_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_en) |-> (flag_q[4:0] == 5'b0));

  p_wake_gate_r10: assert property (@(posedge clk) disable iff (rst)
    stat_irq[4] |-> $past(self_wake && stat_en[4]));

  p_reset_clear_r11: assert property (@(posedge clk)
    $past(rst) |-> (flag_q == '0 && mb_irq == '0 && stat_irq == '0));
endmodule

bind mbi_irq_ctrl mbi_irq_ctrl_chk #(.NUM_MB(NUM_MB), .CW(CW), .NS(5)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mb_irq    (mb_irq),
  .mb_any_irq(mb_any_irq),
  .stat_irq  (stat_irq),
  .cfg_num_mb(cfg_num_mb),
  .flag_q    (flag_q),
  .src_vec   (src_vec),
  .fifo_en   (fifo_en),
  .self_wake (self_wake),
  .stat_en   (stat_en)
);

// File: tb/test_mbi_irq_ctrl.sv
module test_mbi_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [6:0]  cfg_num_mb = 7'd64;
  logic [63:0] mb_done = '0;
  logic        fifo_ovf_evt = 1'b0, fifo_warn_evt = 1'b0, fifo_avail_evt = 1'b0;
  logic [4:0]  stat_evt = '0;
  logic [63:0] mb_irq;
  logic        mb_any_irq;
  logic [4:0]  stat_irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mbi_irq_ctrl i_mbi_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cfg_num_mb(cfg_num_mb), .mb_done(mb_done),
    .fifo_ovf_evt(fifo_ovf_evt), .fifo_warn_evt(fifo_warn_evt),
    .fifo_avail_evt(fifo_avail_evt), .stat_evt(stat_evt),
    .mb_irq(mb_irq), .mb_any_irq(mb_any_irq), .stat_irq(stat_irq)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for read data
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_ren = 1'b1; bus_addr = a;
    tick();
    bus_ren = 1'b0;
  endtask

  task automatic pulse_mb(input logic [63:0] v);
    mb_done = v; tick(); mb_done = '0;
  endtask

  task automatic pulse_st(input logic [4:0] v);
    stat_evt = v; tick(); stat_evt = '0;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R11 reset state
    for (int a = 0; a < 7; a++) rd(3'(a), 32'h0, "R11 reset register");
    chk(mb_irq, 64'h0, "R11 mb_irq after reset");
    chk({59'h0, stat_irq}, 64'h0, "R11 stat_irq after reset");

    // R1 / R2
    pulse_mb(64'h0000_0100_0000_0008);
    rd(3'd0, 32'h8, "R1 low flag set");
    rd(3'd1, 32'h100, "R2 high half bit 8");
    chk(mb_irq, 64'h0, "R3 masked flags give no irq");

    // R3 / R5 / R8
    wr(3'd2, 32'h8);
    tick();
    chk(mb_irq, 64'h8, "R3 irq on buffer 3");
    chk({63'h0, mb_any_irq}, 64'h1, "R5 any irq high");
    rd(3'd2, 32'h8, "R8 mask low readback");

    // R4 clear semantics
    wr(3'd0, 32'h0);
    rd(3'd0, 32'h8, "R4 write 0 keeps flag");
    wr(3'd0, 32'h8);
    rd(3'd0, 32'h0, "R4 write 1 clears flag");
    chk(mb_irq, 64'h0, "R3 irq drops after clear");
    chk({63'h0, mb_any_irq}, 64'h0, "R5 any irq low");
    // set wins over same-cycle clear
    bus_wen = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h8; mb_done = 64'h8;
    tick();
    bus_wen = 1'b0; mb_done = '0;
    rd(3'd0, 32'h8, "R4 set beats clear");
    wr(3'd0, 32'h8);
    rd(3'd0, 32'h0, "R4 clear after race");

    wr(3'd3, 32'hFFFF_FFFF);
    tick();
    chk(mb_irq, 64'h0000_0100_0000_0000, "R3 irq on buffer 40");
    rd(3'd3, 32'hFFFF_FFFF, "R8 mask high readback");

    // R6 configured count
    cfg_num_mb = 7'd16;
    tick();
    rd(3'd1, 32'h0, "R6 high flags cleared by count");
    pulse_mb(64'h0000_0000_0010_0400);
    rd(3'd0, 32'h400, "R6 only bits below count set");
    cfg_num_mb = 7'd64;
    wr(3'd0, 32'h400);
    wr(3'd3, 32'h0);

    // R7 FIFO mode
    wr(3'd6, 32'h1);
    rd(3'd6, 32'h1, "R8 ctrl readback");
    pulse_mb(64'h44);
    rd(3'd0, 32'h0, "R7 mb_done low bits ignored");
    fifo_ovf_evt = 1'b1; tick(); fifo_ovf_evt = 1'b0;
    rd(3'd0, 32'h80, "R7 overflow at bit 7");
    fifo_warn_evt = 1'b1; fifo_avail_evt = 1'b1; tick();
    fifo_warn_evt = 1'b0; fifo_avail_evt = 1'b0;
    rd(3'd0, 32'hE0, "R7 warning and available");
    wr(3'd2, 32'hFF);
    tick();
    chk(mb_irq, 64'hE0, "R7 irq only on bits 7..5");
    wr(3'd0, 32'h20);
    rd(3'd0, 32'hC0, "R7 available cleared");
    wr(3'd6, 32'h0);
    wr(3'd0, 32'hFF);
    wr(3'd2, 32'h0);

    // R9 status flags
    pulse_st(5'b00001);
    rd(3'd4, 32'h1, "R9 bus off latched");
    chk({59'h0, stat_irq}, 64'h0, "R9 disabled source silent");
    wr(3'd5, 32'h1);
    tick();
    chk({59'h0, stat_irq}, 64'h1, "R9 enabled bus off irq");
    wr(3'd4, 32'h1);
    tick();
    chk({59'h0, stat_irq}, 64'h0, "R9 irq drops after clear");
    rd(3'd4, 32'h0, "R9 status cleared");
    pulse_st(5'b00110);
    rd(3'd4, 32'h6, "R9 error and tx warning");
    wr(3'd4, 32'h6);
    rd(3'd5, 32'h1, "R8 enable readback");

    // R10 wake gating, all four combinations
    wr(3'd5, 32'h10);
    pulse_st(5'b10000);
    rd(3'd4, 32'h10, "R10 wake latched");
    tick();
    chk({63'h0, stat_irq[4]}, 64'h0, "R10 en=1 self=0");
    wr(3'd6, 32'h2);
    tick();
    chk({63'h0, stat_irq[4]}, 64'h1, "R10 en=1 self=1");
    wr(3'd5, 32'h0);
    tick();
    chk({63'h0, stat_irq[4]}, 64'h0, "R10 en=0 self=1");
    wr(3'd6, 32'h0);
    tick();
    chk({63'h0, stat_irq[4]}, 64'h0, "R10 en=0 self=0");

    while (exp_q.size() != 0) tick();
    tick();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule